// File: doc/BRIEF.md
# Cascadable Decimal Rate Multiplier

This block thins a stream of input events. It takes a one-cycle strobe for each input event and a program made of `DIGITS` BCD digits. For every window of 10^DIGITS strobes it passes on exactly as many strobes as the program's decimal value. With `DIGITS` = 3 and a program of 234, it emits 234 pulses per 1000 strobes. Each emitted pulse belongs to one accepted strobe, so the output rate is the input rate scaled by Nr / 10^DIGITS.

Each digit has its own decade slice, which is a synchronous counter running from 0 to 9. The most significant slice advances on every strobe. Each lower slice advances only on a strobe where all slices above it sit at count 9, which is the strobe on which the slice above wraps. A slice gates its digit's bits against fixed sets of count values. The slices' gated strobes are ORed into one registered output. Count 9 of every slice carries no gate of its own, so the lower slices never collide with the upper ones. Within one decade the selected count values are spread across the ten counts.

The program is captured on the first strobe after reset or clear, and again on the last strobe of every window. A change on `prog_i` therefore takes effect at the next window boundary. Typical use is ahead of a divider, where it removes a programmed fraction of input pulses to form a fractional divide ratio.

Top module: `rm_bcd_rate_mult`

## Requirements
- R1: When only the most significant digit d is non-zero, every group of 10 consecutive strobes produces exactly d pulses. Groups are counted from the first strobe after reset or clear.
- R2: When only the most significant digit d (1 to 9) is non-zero, two consecutive pulses within a window are never more than ceil(10/d)+1 strobes apart.
- R3: The program digits sit most significant first: `prog_i[4*DIGITS-1 -: 4]` holds the 10^-1 digit and `prog_i[3:0]` the 10^-DIGITS digit. For a program of decimal value Nr, every window of 10^DIGITS strobes yields exactly Nr pulses.
- R4: `pulse_o` is high for one cycle. It rises only in the clock cycle that follows a rising edge at which `stb_i` was high.
- R5: A program digit with a value from 10 to 15 acts exactly like 9. For example, digits 0xC, 0x2, 0xB give 929 pulses per 1000 strobes.
- R6: A change of `prog_i` inside a window does not affect that window. The new value governs the window that starts after the window's last strobe.
- R7: `clr_i` high at a clock edge does three things. It returns every decade to count 0, it forces `pulse_o` low in the next cycle, and it discards any strobe in the same cycle. The next strobe then starts a new window and captures `prog_i` afresh.
- R8: While `rst_n_i` is low, and after it is released until the first strobe, `pulse_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| clr_i | input | 1 | Synchronous restart of the window and the program capture |
| stb_i | input | 1 | One input event per cycle that is high |
| prog_i | input | 4*DIGITS | BCD program, most significant digit in the top nibble |
| pulse_o | output | 1 | Thinned event strobe, one cycle after the strobe it passes |

## Verification
A passed strobe shows on `pulse_o` one clock after the edge at which it was taken. The bench drives just after the rising edge and samples at the falling edge. At that sampling point it credits a high `pulse_o` to the strobe seen at the previous falling edge. A window total is compared at the falling edge after the window's last strobe, when that strobe's result has just become visible. The group-of-ten count and the spacing figures are updated at the same points. The quiet output after a clear is checked at the first falling edge after the clearing edge.

// File: rtl/rm_pkg.sv
package rm_pkg;

  localparam int unsigned BCD_W = 4;
  localparam logic [BCD_W-1:0] BCD_TOP = 4'd9;

  typedef logic [BCD_W-1:0] bcd_t;

  // Values 10..15 behave as the largest decimal digit.
  function automatic bcd_t bcd_clamp(input bcd_t raw);
    return (raw > BCD_TOP) ? BCD_TOP : raw;
  endfunction

  // Slot map over counts 0..8 (count 9 is kept free for the lower decades):
  //   bit 3 (8 slots): every count 0..8 except 4
  //   bit 2 (4 slots): 0, 2, 5, 7
  //   bit 1 (2 slots): 3, 8
  //   bit 0 (1 slot) : 4
  // Bits 2..0 are mutually disjoint and bit 0 is disjoint from bit 3, so any
  // digit 0..9 hits exactly its own value of slots.
  function automatic logic slot_match(input bcd_t cnt, input bcd_t dig);
    logic s8, s4, s2, s1;
    s8 = (cnt <= 4'd8) && (cnt != 4'd4);
    s4 = (cnt == 4'd0) || (cnt == 4'd2) || (cnt == 4'd5) || (cnt == 4'd7);
    s2 = (cnt == 4'd3) || (cnt == 4'd8);
    s1 = (cnt == 4'd4);
    return (dig[3] & s8) | (dig[2] & s4) | (dig[1] & s2) | (dig[0] & s1);
  endfunction

endpackage

// File: rtl/rm_rst_sync.sv
module rm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/rm_decade.sv
module rm_decade
  import rm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic clr_i,
  input  logic adv_i,
  input  bcd_t digit_i,
  output logic nine_o,
  output logic hit_o,
  output bcd_t cnt_o
);

  bcd_t cnt_q;
  bcd_t cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (adv_i) begin
      cnt_d = (cnt_q == BCD_TOP) ? '0 : cnt_q + 4'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign nine_o = (cnt_q == BCD_TOP);
  assign hit_o  = adv_i & slot_match(cnt_q, digit_i);
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/rm_prog_hold.sv
module rm_prog_hold
  import rm_pkg::*;
#(
  parameter int unsigned DIGITS = 3,
  localparam int unsigned PW = BCD_W * DIGITS
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          clr_i,
  input  logic          stb_i,
  input  logic          wrap_i,
  input  logic [PW-1:0] prog_i,
  output logic [PW-1:0] eff_o,
  output logic [PW-1:0] held_o,
  output logic          fresh_o
);

  logic [PW-1:0] clamped;
  logic [PW-1:0] held_q, held_d;
  logic          fresh_q, fresh_d;
  logic          take;

  for (genvar j = 0; j < DIGITS; j++) begin : g_clamp
    assign clamped[BCD_W*j +: BCD_W] = bcd_clamp(prog_i[BCD_W*j +: BCD_W]);
  end

  assign take = !clr_i && stb_i && (fresh_q || wrap_i);

  always_comb begin
    held_d  = held_q;
    fresh_d = fresh_q;
    if (take) begin
      held_d = clamped;
    end
    if (clr_i) begin
      fresh_d = 1'b1;
    end else if (stb_i) begin
      fresh_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      held_q  <= '0;
      fresh_q <= 1'b1;
    end else begin
      held_q  <= held_d;
      fresh_q <= fresh_d;
    end
  end

  // A fresh window gates its first strobe with the live program.
  assign eff_o   = fresh_q ? clamped : held_q;
  assign held_o  = held_q;
  assign fresh_o = fresh_q;

endmodule

// File: rtl/rm_bcd_rate_mult.sv
module rm_bcd_rate_mult #(
  parameter int unsigned DIGITS      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PW = 4 * DIGITS
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          clr_i,
  input  logic          stb_i,
  input  logic [PW-1:0] prog_i,
  output logic          pulse_o
);

  logic              rst_n_s;
  logic [DIGITS-1:0] adv;
  logic [DIGITS-1:0] nine;
  logic [DIGITS-1:0] hit;
  logic [PW-1:0]     eff;
  logic [PW-1:0]     held;
  logic [PW-1:0]     cnt_flat;
  logic              fresh;
  logic              wrap;
  logic              pulse_q, pulse_d;

  rm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_s)
  );

  // Slice j carries the digit of weight 10^-(j+1), stored in the nibble at
  // bit 4*(DIGITS-1-j).
  for (genvar j = 0; j < DIGITS; j++) begin : g_dec
    localparam int unsigned LSB = 4 * (DIGITS - 1 - j);
    if (j == 0) begin : g_head
      assign adv[j] = stb_i;
    end else begin : g_tail
      assign adv[j] = adv[j-1] & nine[j-1];
    end
    rm_decade u_dec (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_s),
      .clr_i   (clr_i),
      .adv_i   (adv[j]),
      .digit_i (eff[LSB +: 4]),
      .nine_o  (nine[j]),
      .hit_o   (hit[j]),
      .cnt_o   (cnt_flat[LSB +: 4])
    );
  end

  assign wrap = adv[DIGITS-1] & nine[DIGITS-1];

  rm_prog_hold #(.DIGITS(DIGITS)) u_hold (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_s),
    .clr_i   (clr_i),
    .stb_i   (stb_i),
    .wrap_i  (wrap),
    .prog_i  (prog_i),
    .eff_o   (eff),
    .held_o  (held),
    .fresh_o (fresh)
  );

  always_comb begin
    pulse_d = 1'b0;
    if (!clr_i) begin
      pulse_d = |hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/rm_bcd_rate_mult_chk.sv
module rm_bcd_rate_mult_chk #(
  parameter int unsigned DIGITS = 3,
  localparam int unsigned PW = 4 * DIGITS
) (
  input logic          clk_i,
  input logic          rst_n_i,
  input logic          clr_i,
  input logic          stb_i,
  input logic          pulse_o,
  input logic          wrap,
  input logic          fresh,
  input logic [PW-1:0] cnt_flat,
  input logic [PW-1:0] held_flat
);

  AST_PULSE_NEEDS_STB: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    pulse_o |-> $past(stb_i)); // R4

  AST_CLR_SILENCES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clr_i |=> !pulse_o); // R7

  AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clr_i |=> (cnt_flat == '0)); // R7

  AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!stb_i && !clr_i) |=> $stable(cnt_flat)); // R3

  AST_HELD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (clr_i || !(stb_i && (fresh || wrap))) |=> $stable(held_flat)); // R6

  for (genvar j = 0; j < DIGITS; j++) begin : g_dig
    AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      cnt_flat[4*j +: 4] <= 4'd9); // R3

    AST_HELD_CLAMPED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      held_flat[4*j +: 4] <= 4'd9); // R5
  end

endmodule

bind rm_bcd_rate_mult rm_bcd_rate_mult_chk #(.DIGITS(DIGITS)) chk_i (
  .clk_i     (clk_i),
  .rst_n_i   (rst_n_s),
  .clr_i     (clr_i),
  .stb_i     (stb_i),
  .pulse_o   (pulse_o),
  .wrap      (wrap),
  .fresh     (fresh),
  .cnt_flat  (cnt_flat),
  .held_flat (held)
);

// File: tb/rm_bcd_rate_mult_tb_top.sv
module rm_bcd_rate_mult_tb_top;

  localparam int DIGITS = 3;
  localparam int PW     = 4 * DIGITS;
  localparam int WIN    = 1000;

  typedef struct {
    int    total;
    int    blk_d;
    int    max_gap;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr;
  logic          stb;
  logic [PW-1:0] prog;
  logic          pulse;

  always #2 clk = ~clk;

  rm_bcd_rate_mult #(.DIGITS(DIGITS)) dut_i (
    .clk_i   (clk),
    .rst_n_i (rst_n),
    .clr_i   (clr),
    .stb_i   (stb),
    .prog_i  (prog),
    .pulse_o (pulse)
  );

  exp_t sb_q[$];
  int   checks   = 0;
  int   failures = 0;
  int   r4_bad   = 0;
  bit   done     = 1'b0;
  bit   mon_on   = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dig_of(input logic [PW-1:0] p, input int j);
    int d;
    d = int'(p[PW-1-4*j -: 4]);
    return (d > 9) ? 9 : d;
  endfunction

  function automatic int prog_value(input logic [PW-1:0] p);
    int v = 0;
    for (int j = 0; j < DIGITS; j++) v = v * 10 + dig_of(p, j);
    return v;
  endfunction

  // ---------------- driver ----------------
  logic [15:0]   lfsr = 16'hACE1;
  bit            gappy = 1'b0;
  logic [PW-1:0] cur_prog;

  task automatic one_cycle(input bit s);
    @(posedge clk);
    #1;
    stb  = s;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic give_strobe();
    while (gappy && lfsr[1:0] == 2'b00) one_cycle(1'b0);
    one_cycle(1'b1);
  endtask

  function automatic exp_t make_item(input logic [PW-1:0] p, input string tag);
    exp_t it;
    int   top, rest;
    top  = dig_of(p, 0);
    rest = prog_value(p) - top * (10 ** (DIGITS - 1));
    it.total   = prog_value(p);
    it.tag     = tag;
    it.blk_d   = -1;
    it.max_gap = 0;
    if (rest == 0) begin
      it.blk_d = top;
      if (top > 0) it.max_gap = (10 + top - 1) / top + 1;
    end
    return it;
  endfunction

  // One full window with the captured program; prog_i moves to next_p halfway (R6).
  task automatic run_window(input logic [PW-1:0] next_p, input bit gap_on);
    sb_q.push_back(make_item(cur_prog, $sformatf("prog=%03h", cur_prog)));
    gappy = gap_on;
    for (int i = 0; i < WIN; i++) begin
      if (i == WIN / 2) prog = next_p;
      give_strobe();
    end
    cur_prog = next_p;
  endtask

  // ---------------- monitor / scoreboard ----------------
  bit prev_stb      = 1'b0;
  bit clr_pending   = 1'b0;
  int strobes_seen  = 0;
  int win_pulses    = 0;
  int blk_pulses    = 0;
  int last_idx      = -1;
  int max_seen_gap  = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (clr_pending) begin
        check(pulse == 1'b0, "R7", "pulse after clear", int'(pulse), 0);
        clr_pending = 1'b0;
      end else if (pulse) begin
        if (!prev_stb) begin
          r4_bad++;
          failures++;
          $display("FAIL R4 pulse without strobe actual=1 expected=0");
        end else begin
          win_pulses++;
          blk_pulses++;
          if (last_idx >= 0 && strobes_seen - last_idx > max_seen_gap)
            max_seen_gap = strobes_seen - last_idx;
          last_idx = strobes_seen;
        end
      end
      if (prev_stb && sb_q.size() > 0) begin
        strobes_seen++;
        if (strobes_seen % 10 == 0) begin
          if (sb_q[0].blk_d >= 0)
            check(blk_pulses == sb_q[0].blk_d, "R1",
                  $sformatf("group of ten %s", sb_q[0].tag), blk_pulses, sb_q[0].blk_d);
          blk_pulses = 0;
        end
        if (strobes_seen == WIN) begin
          check(win_pulses == sb_q[0].total, "R3/R5/R6",
                $sformatf("window total %s", sb_q[0].tag), win_pulses, sb_q[0].total);
          if (sb_q[0].max_gap > 0)
            check(max_seen_gap <= sb_q[0].max_gap, "R2",
                  $sformatf("largest gap %s", sb_q[0].tag), max_seen_gap, sb_q[0].max_gap);
          void'(sb_q.pop_front());
          strobes_seen = 0;
          win_pulses   = 0;
          blk_pulses   = 0;
          last_idx     = -1;
          max_seen_gap = 0;
        end
      end
      if (clr) begin
        strobes_seen = 0;
        win_pulses   = 0;
        blk_pulses   = 0;
        last_idx     = -1;
        max_seen_gap = 0;
        clr_pending  = 1'b1;
        prev_stb     = 1'b0;
      end else begin
        prev_stb = stb;
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog expired actual=%0d expected=0", sb_q.size());
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [PW-1:0] plist [16] = '{12'h234, 12'h999, 12'h000, 12'h007, 12'h050,
                                12'hC2B, 12'h100, 12'h200, 12'h300, 12'h400,
                                12'h500, 12'h600, 12'h700, 12'h800, 12'h900,
                                12'hF00};

  initial begin
    rst_n = 1'b0;
    clr   = 1'b0;
    stb   = 1'b0;
    prog  = 12'h300;
    repeat (3) begin
      @(negedge clk);
      check(pulse == 1'b0, "R8", "pulse in reset", int'(pulse), 0);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check(pulse == 1'b0, "R8", "pulse after release", int'(pulse), 0);
    end
    @(posedge clk);
    #1;
    mon_on   = 1'b1;
    cur_prog = prog;

    // R1 R2 R3 R5 R6: each window runs on the program captured before it.
    for (int i = 0; i < 16; i++) run_window(plist[i], i[0]);
    run_window(12'h400, 1'b1);

    // R7: abandon a window partway, then clear with a strobe on the same cycle.
    sb_q.push_back(make_item(cur_prog, "partial"));
    gappy = 1'b1;
    for (int i = 0; i < 437; i++) give_strobe();
    one_cycle(1'b0);
    one_cycle(1'b0);
    void'(sb_q.pop_front());
    @(posedge clk);
    #1;
    prog = 12'h090;
    clr  = 1'b1;
    stb  = 1'b1;
    @(posedge clk);
    #1;
    clr = 1'b0;
    stb = 1'b0;
    cur_prog = 12'h090;
    run_window(12'h060, 1'b0);
    run_window(12'h060, 1'b1);

    repeat (4) one_cycle(1'b0);
    check(sb_q.size() == 0, "R3", "windows left open", sb_q.size(), 0);
    check(r4_bad == 0, "R4", "pulses without strobe", r4_bad, 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule